// File: doc/BRIEF.md
# Dual-Channel Host Mailbox Interface

This block gives a host processor two byte-wide mailboxes into a local controller, each reached through a pair of I/O ports on a simple strobe-based host bus. Channel 0 carries power-management traffic and channel 1 carries general command traffic. In each channel the host writes a byte to either the command port or the data port. Reading the command port returns that channel's status byte. Reading the data port returns the response byte.

On the local side, firmware sees one shared input interrupt. It also sees a service pointer that names the channel to handle next. Firmware reads the input byte, which frees the channel for the next host write, and then writes a response. It keeps a per-channel busy flag that the host can see. On channel 0 it also drives two event-pending status bits. When the host drains a full output register, a one-cycle output-empty pulse reports it to firmware. A host platform reset forces the command channel's busy flag clear.

Top module: `host_mailbox_pair`

## Requirements
- R1: A host write to a channel's command or data port stores the byte and sets status bit 1 (input full). Status bit 3 becomes 1 for the command port and 0 for the data port.
- R2: A local read of the selected channel's input register returns the stored byte on `l_rdata` one cycle later and clears input full.
- R3: A local write sets status bit 2 (output full). A host read of the data port returns the byte and clears output full. `irq_obe[ch]` pulses for one cycle only when output full was set and no local write occurs in the same cycle.
- R4: Status bit 0 (busy) is set by `l_set_busy` and cleared by `l_clr_busy` on the selected channel. If both are given together, the clear wins.
- R5: While `plat_rst` is high, channel 1's busy flag is forced clear. Channel 0's busy flag is unaffected.
- R6: When both channels have an enabled input-full flag, `svc_ch` is 0. `svc_valid` is high whenever any enabled input-full flag is set.
- R7: `irq_ibf` is the OR of the input-full flags gated by `irq_en[ch]`. A channel whose enable is low never raises it.
- R8: An event write with `l_ch`=0 loads status bit 5 (SCI pending) and bit 6 (SMI pending) of channel 0. With `l_ch`=1 the event write has no effect, and channel 1 always reads 0 in those bits. Status bits 4 and 7 always read 0.
- R9: The port addresses are: channel 0 command 0x066, channel 0 data 0x062, channel 1 command 0x200, channel 1 data 0x204. A host write to any other address changes nothing. A host read of any other address returns 0xFF.
- R10: After reset all flags are 0, `h_rdata` is 0xFF, `l_rdata` is 0, and every interrupt output and `svc_valid` are low.
- R11: If a host write and a local read hit the same channel in the same cycle, the local read returns the old byte and input full stays set with the new byte.
- R12: `h_rdata` is registered: it shows the value addressed by a host read one cycle after the strobe and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| plat_rst | input | 1 | Host platform reset level |
| h_addr | input | 16 | Host I/O address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Registered host read byte |
| l_ch | input | 1 | Local channel select |
| l_rd_in | input | 1 | Local read of input register |
| l_wr_out | input | 1 | Local write of output register |
| l_wdata | input | 8 | Local response byte |
| l_rdata | output | 8 | Registered local input byte |
| l_set_busy | input | 1 | Set busy flag on selected channel |
| l_clr_busy | input | 1 | Clear busy flag on selected channel |
| l_evt_we | input | 1 | Event-bit write strobe |
| l_evt_sci | input | 1 | SCI-pending value |
| l_evt_smi | input | 1 | SMI-pending value |
| irq_en | input | 2 | Per-channel input interrupt enable |
| irq_ibf | output | 1 | Shared input-full interrupt |
| irq_obe | output | 2 | Per-channel output-empty pulse |
| svc_valid | output | 1 | Some enabled channel has input full |
| svc_ch | output | 1 | Channel to service next |

## Verification
A wrong flag inside a channel shows up in the status byte on the very next host read of the command port. A wrong flag can also appear as a wrong level on `irq_ibf`, `svc_valid` or `svc_ch` within one cycle of the event that caused it. A stored byte that is lost or crossed between channels shows up only when it is drained: at the next local input read, or at the next host data-port read. For this reason the stimulus interleaves writes, drains and status reads on both channels. Priority and gating errors only appear when both channels are full at once or when enables differ, so those states are built on purpose.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ST_BUSY = 0;
  localparam int ST_IBF  = 1;
  localparam int ST_OBF  = 2;
  localparam int ST_CMD  = 3;
  localparam int ST_SCI  = 5;
  localparam int ST_SMI  = 6;

  typedef struct packed {
    logic busy;
    logic ibf;
    logic obf;
    logic cmd;
    logic sci;
    logic smi;
  } mbx_flags_t;

  function automatic logic [7:0] pack_status(mbx_flags_t f);
    logic [7:0] s;
    s = '0;
    s[ST_BUSY] = f.busy;
    s[ST_IBF]  = f.ibf;
    s[ST_OBF]  = f.obf;
    s[ST_CMD]  = f.cmd;
    s[ST_SCI]  = f.sci;
    s[ST_SMI]  = f.smi;
    return s;
  endfunction
endpackage

// File: rtl/mbx_channel.sv
module mbx_channel
  import mbx_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] CMD_ADDR  = 16'h0066,
  parameter logic [AW-1:0] DATA_ADDR = 16'h0062
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          force_idle,
  input  logic [AW-1:0] h_addr,
  input  logic          h_wr,
  input  logic          h_rd,
  input  logic [DW-1:0] h_wdata,
  input  logic          sel,
  input  logic          l_rd_in,
  input  logic          l_wr_out,
  input  logic [DW-1:0] l_wdata,
  input  logic          l_set_busy,
  input  logic          l_clr_busy,
  input  logic          evt_we,
  input  logic          evt_sci,
  input  logic          evt_smi,
  output logic [DW-1:0] in_byte,
  output logic [DW-1:0] out_byte,
  output logic [7:0]    status,
  output logic          ibf,
  output logic          hit_cmd,
  output logic          hit_data,
  output logic          obe_pulse
);
  logic [DW-1:0] in_q, out_q;
  logic ibf_q, obf_q, cmd_q, busy_q, sci_q, smi_q, obe_q;
  logic hw, lr, lw, ls, lc, hdr;
  mbx_flags_t flags;

  assign hit_cmd  = (h_addr == CMD_ADDR);
  assign hit_data = (h_addr == DATA_ADDR);
  assign hw  = h_wr && (hit_cmd || hit_data);
  assign hdr = h_rd && hit_data;
  assign lr  = sel && l_rd_in;
  assign lw  = sel && l_wr_out;
  assign ls  = sel && l_set_busy;
  assign lc  = sel && l_clr_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q   <= '0;
      out_q  <= '0;
      ibf_q  <= 1'b0;
      obf_q  <= 1'b0;
      cmd_q  <= 1'b0;
      busy_q <= 1'b0;
      sci_q  <= 1'b0;
      smi_q  <= 1'b0;
      obe_q  <= 1'b0;
    end else begin
      if (hw) begin
        in_q  <= h_wdata;
        cmd_q <= hit_cmd;
        ibf_q <= 1'b1;
      end else if (lr) begin
        ibf_q <= 1'b0;
      end
      if (lw) begin
        out_q <= l_wdata;
        obf_q <= 1'b1;
      end else if (hdr) begin
        obf_q <= 1'b0;
      end
      obe_q <= hdr && obf_q && !lw;
      if (force_idle || lc)
        busy_q <= 1'b0;
      else if (ls)
        busy_q <= 1'b1;
      if (evt_we) begin
        sci_q <= evt_sci;
        smi_q <= evt_smi;
      end
    end
  end

  always_comb begin
    flags.busy = busy_q;
    flags.ibf  = ibf_q;
    flags.obf  = obf_q;
    flags.cmd  = cmd_q;
    flags.sci  = sci_q;
    flags.smi  = smi_q;
  end

  assign status    = pack_status(flags);
  assign in_byte   = in_q;
  assign out_byte  = out_q;
  assign ibf       = ibf_q;
  assign obe_pulse = obe_q;

  p_wr_fills_r1: assert property (@(posedge clk) disable iff (rst)
    hw |=> (ibf_q && (cmd_q == $past(hit_cmd)) && (in_q == $past(h_wdata))));
  p_rd_empties_r2: assert property (@(posedge clk) disable iff (rst)
    (lr && !hw) |=> !ibf_q);
  p_wr_out_full_r3: assert property (@(posedge clk) disable iff (rst)
    lw |=> obf_q);
  p_drain_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    (hdr && obf_q && !lw) |=> (!obf_q && obe_q));
  p_clear_wins_r4: assert property (@(posedge clk) disable iff (rst)
    lc |=> !busy_q);
  p_force_idle_r5: assert property (@(posedge clk) disable iff (rst)
    force_idle |=> !busy_q);
  p_collide_r11: assert property (@(posedge clk) disable iff (rst)
    (hw && lr) |=> ibf_q);
endmodule

// File: rtl/mbx_prio.sv
module mbx_prio #(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ibf,
  input  logic [NCH-1:0] ie,
  output logic           irq,
  output logic           valid,
  output logic [CW-1:0]  sel
);
  logic [NCH-1:0] pend;

  assign pend  = ibf & ie;
  assign irq   = |pend;
  assign valid = |pend;

  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) sel = CW'(i);
  end

  p_low_first_r6: assert property (@(posedge clk) disable iff (rst)
    (ibf[0] && ie[0]) |-> (sel == '0));
  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (ie == '0) |-> !irq);
  p_masked_quiet_ch_r7: assert property (@(posedge clk) disable iff (rst)
    (!ibf[0] && ibf[1] && !ie[1]) |-> !irq);
endmodule

// File: rtl/host_mailbox_pair.sv
module host_mailbox_pair #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] PM_CMD_ADDR  = 16'h0066,
  parameter logic [AW-1:0] PM_DATA_ADDR = 16'h0062,
  parameter logic [AW-1:0] HC_CMD_ADDR  = 16'h0200,
  parameter logic [AW-1:0] HC_DATA_ADDR = 16'h0204
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          plat_rst,
  input  logic [AW-1:0] h_addr,
  input  logic          h_wr,
  input  logic          h_rd,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic          l_ch,
  input  logic          l_rd_in,
  input  logic          l_wr_out,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          l_set_busy,
  input  logic          l_clr_busy,
  input  logic          l_evt_we,
  input  logic          l_evt_sci,
  input  logic          l_evt_smi,
  input  logic [1:0]    irq_en,
  output logic          irq_ibf,
  output logic [1:0]    irq_obe,
  output logic          svc_valid,
  output logic          svc_ch
);
  localparam int NCH = 2;

  logic [DW-1:0] in_b  [NCH];
  logic [DW-1:0] out_b [NCH];
  logic [7:0]    st_b  [NCH];
  logic [NCH-1:0] ibf_v, hc_v, hd_v, obe_v;
  logic [DW-1:0] rd_next;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic ch_sel;
    assign ch_sel = (l_ch == 1'(g));
    mbx_channel #(
      .AW(AW), .DW(DW),
      .CMD_ADDR (g == 0 ? PM_CMD_ADDR  : HC_CMD_ADDR),
      .DATA_ADDR(g == 0 ? PM_DATA_ADDR : HC_DATA_ADDR)
    ) u_chan (
      .clk(clk), .rst(rst),
      .force_idle(g == 1 ? plat_rst : 1'b0),
      .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata),
      .sel(ch_sel), .l_rd_in(l_rd_in), .l_wr_out(l_wr_out), .l_wdata(l_wdata),
      .l_set_busy(l_set_busy), .l_clr_busy(l_clr_busy),
      .evt_we(g == 0 ? (l_evt_we && ch_sel) : 1'b0),
      .evt_sci(l_evt_sci), .evt_smi(l_evt_smi),
      .in_byte(in_b[g]), .out_byte(out_b[g]), .status(st_b[g]),
      .ibf(ibf_v[g]), .hit_cmd(hc_v[g]), .hit_data(hd_v[g]),
      .obe_pulse(obe_v[g])
    );
  end

  always_comb begin
    rd_next = '1;
    for (int i = 0; i < NCH; i++) begin
      if (hc_v[i]) rd_next = DW'(st_b[i]);
      if (hd_v[i]) rd_next = out_b[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rdata <= '1;
      l_rdata <= '0;
    end else begin
      if (h_rd)    h_rdata <= rd_next;
      if (l_rd_in) l_rdata <= in_b[l_ch];
    end
  end

  assign irq_obe = obe_v;

  mbx_prio #(.NCH(NCH)) u_prio (
    .clk(clk), .rst(rst), .ibf(ibf_v), .ie(irq_en),
    .irq(irq_ibf), .valid(svc_valid), .sel(svc_ch)
  );

  p_miss_reads_ff_r9: assert property (@(posedge clk) disable iff (rst)
    (h_rd && !(|hc_v) && !(|hd_v)) |=> (h_rdata == '1));
  p_rdata_holds_r12: assert property (@(posedge clk) disable iff (rst)
    !h_rd |=> $stable(h_rdata));
endmodule

// File: tb/host_mailbox_pair_bench.sv
module host_mailbox_pair_bench;
  logic clk = 0, rst = 1, plat_rst = 0;
  logic [15:0] h_addr = 0;
  logic h_wr = 0, h_rd = 0;
  logic [7:0] h_wdata = 0, h_rdata, l_wdata = 0, l_rdata;
  logic l_ch = 0, l_rd_in = 0, l_wr_out = 0, l_set_busy = 0, l_clr_busy = 0;
  logic l_evt_we = 0, l_evt_sci = 0, l_evt_smi = 0;
  logic [1:0] irq_en = 2'b11, irq_obe;
  logic irq_ibf, svc_valid, svc_ch;

  always #5 clk = ~clk;

  host_mailbox_pair u_host_mailbox_pair (
    .clk(clk), .rst(rst), .plat_rst(plat_rst), .h_addr(h_addr), .h_wr(h_wr),
    .h_rd(h_rd), .h_wdata(h_wdata), .h_rdata(h_rdata), .l_ch(l_ch),
    .l_rd_in(l_rd_in), .l_wr_out(l_wr_out), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .l_set_busy(l_set_busy), .l_clr_busy(l_clr_busy), .l_evt_we(l_evt_we),
    .l_evt_sci(l_evt_sci), .l_evt_smi(l_evt_smi), .irq_en(irq_en),
    .irq_ibf(irq_ibf), .irq_obe(irq_obe), .svc_valid(svc_valid), .svc_ch(svc_ch)
  );

  int nchk = 0, nerr = 0;
  logic [7:0] m_in [2], m_out [2];
  bit m_ibf [2], m_obf [2], m_busy [2], m_cmd [2];
  bit m_sci = 0, m_smi = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cmd_a(int c);
    return (c == 0) ? 16'h0066 : 16'h0200;
  endfunction
  function automatic logic [15:0] dat_a(int c);
    return (c == 0) ? 16'h0062 : 16'h0204;
  endfunction
  function automatic logic [7:0] exp_stat(int c);
    logic [7:0] s = 8'h00;
    s[0] = m_busy[c]; s[1] = m_ibf[c]; s[2] = m_obf[c]; s[3] = m_cmd[c];
    if (c == 0) begin s[5] = m_sci; s[6] = m_smi; end
    return s;
  endfunction

  task automatic check_irq(string tag);
    bit p0, p1;
    p0 = m_ibf[0] && irq_en[0];
    p1 = m_ibf[1] && irq_en[1];
    chk({tag, " R7 irq_ibf"}, irq_ibf, p0 || p1);
    chk({tag, " R6 svc_valid"}, svc_valid, p0 || p1);
    chk({tag, " R6 svc_ch"}, svc_ch, (!p0 && p1) ? 1 : 0);
  endtask

  task automatic host_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1;
    @(negedge clk); h_wr = 0;
    for (int c = 0; c < 2; c++) begin
      if (a == cmd_a(c) || a == dat_a(c)) begin
        m_in[c] = d; m_ibf[c] = 1; m_cmd[c] = (a == cmd_a(c));
      end
    end
  endtask

  task automatic host_read(logic [15:0] a, output logic [7:0] r, output logic [1:0] ob);
    @(negedge clk); h_addr = a; h_rd = 1;
    @(negedge clk); h_rd = 0; r = h_rdata; ob = irq_obe;
  endtask

  task automatic check_status(int c, string req);
    logic [7:0] r; logic [1:0] ob;
    host_read(cmd_a(c), r, ob);
    chk({req, " status"}, r, exp_stat(c));
  endtask

  task automatic drain_out(int c);
    logic [7:0] r; logic [1:0] ob; logic [1:0] eob;
    eob = 2'b00; eob[c] = m_obf[c];
    host_read(dat_a(c), r, ob);
    chk("R3 data byte", r, m_out[c]);
    chk("R3 obe pulse", ob, eob);
    m_obf[c] = 0;
  endtask

  task automatic local_read(int c);
    @(negedge clk); l_ch = 1'(c); l_rd_in = 1;
    @(negedge clk); l_rd_in = 0;
    chk("R2 local byte", l_rdata, m_in[c]);
    m_ibf[c] = 0;
  endtask

  task automatic local_write(int c, logic [7:0] d);
    @(negedge clk); l_ch = 1'(c); l_wdata = d; l_wr_out = 1;
    @(negedge clk); l_wr_out = 0;
    m_out[c] = d; m_obf[c] = 1;
  endtask

  task automatic busy_op(int c, bit s, bit k);
    @(negedge clk); l_ch = 1'(c); l_set_busy = s; l_clr_busy = k;
    @(negedge clk); l_set_busy = 0; l_clr_busy = 0;
    if (k) m_busy[c] = 0; else if (s) m_busy[c] = 1;
  endtask

  task automatic evt_op(int c, bit sc, bit sm);
    @(negedge clk); l_ch = 1'(c); l_evt_sci = sc; l_evt_smi = sm; l_evt_we = 1;
    @(negedge clk); l_evt_we = 0;
    if (c == 0) begin m_sci = sc; m_smi = sm; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] r; logic [1:0] ob;
    void'($urandom(32'd2024));
    for (int c = 0; c < 2; c++) begin
      m_in[c] = 0; m_out[c] = 0; m_ibf[c] = 0; m_obf[c] = 0; m_busy[c] = 0; m_cmd[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 h_rdata", h_rdata, 8'hFF);
    chk("R10 l_rdata", l_rdata, 8'h00);
    chk("R10 irq_obe", irq_obe, 2'b00);
    check_irq("R10");
    check_status(0, "R10");
    check_status(1, "R10");

    // R1 command vs data tag
    host_write(16'h0066, 8'hA5); check_status(0, "R1 cmd");
    host_write(16'h0204, 8'h3C); check_status(1, "R1 data");
    // R6 priority: both full
    check_irq("R6 both");
    irq_en = 2'b10; @(negedge clk); check_irq("R7 ch0 masked");
    irq_en = 2'b00; @(negedge clk); check_irq("R7 all masked");
    irq_en = 2'b11;
    local_read(0); check_irq("R6 after drain"); local_read(1);

    // R9 unmapped addresses
    host_write(16'h0063, 8'h77); check_status(0, "R9 ignored");
    check_status(1, "R9 ignored");
    host_read(16'h0300, r, ob); chk("R9 miss read", r, 8'hFF);
    // R12 hold
    repeat (3) @(negedge clk); chk("R12 hold", h_rdata, 8'hFF);

    // R11 collision
    host_write(16'h0062, 8'h11);
    @(negedge clk); h_addr = 16'h0066; h_wdata = 8'h22; h_wr = 1; l_ch = 0; l_rd_in = 1;
    @(negedge clk); h_wr = 0; l_rd_in = 0;
    chk("R11 old byte", l_rdata, 8'h11);
    m_in[0] = 8'h22; m_ibf[0] = 1; m_cmd[0] = 1;
    check_status(0, "R11");
    local_read(0);

    // R4 clear wins, R5 platform reset
    busy_op(1, 1, 0); check_status(1, "R4 set");
    busy_op(1, 1, 1); check_status(1, "R4 clear wins");
    busy_op(0, 1, 0); busy_op(1, 1, 0);
    @(negedge clk); plat_rst = 1; l_ch = 1; l_set_busy = 1;
    @(negedge clk); plat_rst = 0; l_set_busy = 0; m_busy[1] = 0;
    check_status(1, "R5 forced"); check_status(0, "R5 ch0 kept");

    // R8 event bits
    evt_op(0, 1, 1); check_status(0, "R8 set");
    evt_op(1, 0, 0); check_status(0, "R8 ch1 ignored"); check_status(1, "R8 ch1 zero");

    // R3 drain without full gives no pulse
    drain_out(0);
    local_write(0, 8'h5A); check_status(0, "R3 full"); drain_out(0);

    for (int i = 0; i < 400; i++) begin
      int c, op;
      c = $urandom % 2;
      op = $urandom % 10;
      case (op)
        0, 1: host_write(($urandom % 2) ? cmd_a(c) : dat_a(c), 8'($urandom));
        2: check_status(c, "R1 rnd");
        3: drain_out(c);
        4: local_read(c);
        5: local_write(c, 8'($urandom));
        6: busy_op(c, $urandom % 2, $urandom % 2);
        7: evt_op(c, $urandom % 2, $urandom % 2);
        8: begin
          @(negedge clk); plat_rst = 1;
          @(negedge clk); plat_rst = 0; m_busy[1] = 0;
          check_status(1, "R5 rnd");
        end
        default: begin irq_en = 2'($urandom); @(negedge clk); end
      endcase
      check_irq("rnd");
    end

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule